// File: doc/BRIEF.md
# Fractional-Nanosecond Time-of-Day Clock

This block keeps the local time of a precision-time node. It runs on one clock and holds a 48-bit seconds count and a nanoseconds accumulator. The accumulator keeps 30 integer bits and 32 fractional bits. On every cycle it adds a rate step written in 8.32 fixed point, that is 8 integer nanosecond bits and 32 fraction bits. When the accumulator reaches a programmable rollover value, given in 30.8 fixed point, it wraps and carries one second. Because both the step and the rollover are programmable, one design serves any reference clock frequency and can be trimmed to sub-nanosecond accuracy.

Four single-cycle strobes control the block, all synchronous to its clock:
- A clear strobe zeroes the time and the rate state.
- A time-load strobe writes an absolute time.
- A rate-load strobe changes the normal step.
- A slew strobe replaces the normal step with an alternate step for a programmed number of cycles. Servo software uses this to pull the phase without disturbing the nominal frequency.

The outputs show the seconds and the nanoseconds at 30.8 resolution. The lower 24 fraction bits stay internal, so sub-resolution steps still build up over many cycles.

Top module: `ptp_tod_clock`

## Requirements
- R1: While `rst_n` is low, and right after it is released, `sec_o` and `ns_o` read zero. After reset the normal step is zero, so the time holds still until a rate-load strobe arrives.
- R2: On a cycle with no strobe, the internal accumulator grows by the active step with all 32 fraction bits kept. `ns_o` shows accumulator bits [61:24], which are 30 integer bits over 8 fraction bits. A step of 2^-9 ns therefore raises `ns_o` by one LSB only every second cycle.
- R3: If the accumulator plus the step is greater than or equal to the rollover value, the accumulator becomes the sum minus the rollover value. `sec_o` rises by one on that same clock edge.
- R4: A time-load strobe sets `sec_o` to `tload_sec_i` and `ns_o` to `tload_ns_i` one cycle later. No step is added on that cycle, and the hidden fraction bits are cleared.
- R5: A rate-load strobe latches `rate_i` as the normal step. The cycle that carries the strobe still adds the previous step, and the new step applies from the next cycle on.
- R6: A slew strobe with a count N greater than zero makes the N cycles after the strobe add `slew_rate_i` instead of the normal step. The strobe cycle itself adds the step that was already active. After those N cycles the normal step returns.
- R7: A slew strobe with a count of zero leaves the normal step in use.
- R8: A clear strobe zeroes the seconds, the nanoseconds, the normal step and any remaining slew count. After a clear with no later rate load, the time stays at zero.
- R9: When strobes coincide, clear overrides time-load, rate-load and slew. Time-load overrides the per-cycle advance.
- R10: The seconds count wraps from 2^48-1 to 0 on a carry, with no other effect.
- R11: When the sum exactly equals the rollover value, the nanoseconds read zero and a second is carried.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Time-base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_pulse_i | input | 1 | One-cycle clear strobe |
| tload_pulse_i | input | 1 | One-cycle absolute time-load strobe |
| tload_sec_i | input | 48 | Seconds value for a time load |
| tload_ns_i | input | 38 | Nanoseconds value for a time load, 30.8 fixed point |
| rate_load_pulse_i | input | 1 | One-cycle normal-step load strobe |
| rate_i | input | 40 | Normal step, 8.32 fixed point nanoseconds |
| slew_load_pulse_i | input | 1 | One-cycle slew strobe |
| slew_cycles_i | input | 32 | Number of cycles that use the alternate step |
| slew_rate_i | input | 40 | Alternate step, 8.32 fixed point nanoseconds |
| ns_modulo_i | input | 38 | Nanoseconds rollover value, 30.8 fixed point, held steady |
| sec_o | output | 48 | Current seconds |
| ns_o | output | 38 | Current nanoseconds, 30.8 fixed point |

## Verification
The assertions assume the following about the inputs:
- Every step is strictly smaller than the rollover value, so one subtraction is enough to bring the accumulator back into range.
- The rollover value does not change while time runs.

The stimulus keeps a fixed rollover value of 1000 ns and uses steps of at most 10.5 ns. Its time loads stay below the rollover value, so the accumulator never starts out of range. All strobes are driven for one cycle at a time on the falling edge.

// File: rtl/tod_pkg.sv
package tod_pkg;

    // Default geometry of the time value and the rate step
    localparam int unsigned SEC_W_DEF      = 48;
    localparam int unsigned NS_INT_W_DEF   = 30;
    localparam int unsigned NS_VIS_FRAC_DEF = 8;
    localparam int unsigned ACC_FRAC_W_DEF = 32;
    localparam int unsigned STEP_INT_W_DEF = 8;
    localparam int unsigned SLEW_CNT_W_DEF = 32;

    // Which step register feeds the accumulator this cycle
    typedef enum logic {
        STEP_NORMAL = 1'b0,
        STEP_ALT    = 1'b1
    } step_src_e;

endpackage

// File: rtl/tod_rate_ctrl.sv
module tod_rate_ctrl #(
    parameter int unsigned STEP_W = 40,
    parameter int unsigned CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              rate_ld_i,
    input  logic [STEP_W-1:0] rate_i,
    input  logic              slew_ld_i,
    input  logic [CNT_W-1:0]  slew_cnt_i,
    input  logic [STEP_W-1:0] slew_rate_i,
    output logic [STEP_W-1:0] step_o
);
    import tod_pkg::*;

    localparam logic [CNT_W-1:0] CNT_ONE = 1;

    typedef struct packed {
        logic [STEP_W-1:0] norm;
        logic [STEP_W-1:0] alt;
        logic [CNT_W-1:0]  cnt;
    } rate_t;

    rate_t     st_d, st_q;
    step_src_e src;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.norm = '0;
            st_d.alt  = '0;
            st_d.cnt  = '0;
        end else begin
            if (rate_ld_i) begin
                st_d.norm = rate_i;
            end
            if (slew_ld_i) begin
                st_d.cnt = slew_cnt_i;
                st_d.alt = slew_rate_i;
            end else if (st_q.cnt != '0) begin
                st_d.cnt = st_q.cnt - CNT_ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign src    = (st_q.cnt != '0) ? STEP_ALT : STEP_NORMAL;
    assign step_o = (src == STEP_ALT) ? st_q.alt : st_q.norm;

    // R8: a clear leaves a zero normal step and no active slew
    p_clr_cancel_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (step_o == '0 && src == STEP_NORMAL));

    // R6: the last slew cycle hands back to the normal step
    p_slew_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == CNT_ONE && !slew_ld_i && !clr_i) |=> src == STEP_NORMAL);

    // R7: a zero-length slew never selects the alternate step
    p_slew_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (slew_ld_i && !clr_i && slew_cnt_i == '0) |=> src == STEP_NORMAL);

    // R5: a new normal step is visible on the following cycle
    p_rate_next_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_ld_i && !clr_i && !slew_ld_i && st_q.cnt == '0) |=> step_o == $past(rate_i));

endmodule

// File: rtl/tod_ns_accum.sv
module tod_ns_accum #(
    parameter int unsigned ACC_W    = 62,
    parameter int unsigned STEP_W   = 40,
    parameter int unsigned NS_OUT_W = 38
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr_i,
    input  logic                tload_i,
    input  logic [NS_OUT_W-1:0] tload_ns_i,
    input  logic [STEP_W-1:0]   step_i,
    input  logic [NS_OUT_W-1:0] modulo_i,
    output logic [NS_OUT_W-1:0] ns_o,
    output logic                carry_o
);
    localparam int unsigned PAD_W = ACC_W - NS_OUT_W;
    localparam int unsigned EXT_W = ACC_W + 1 - STEP_W;
    localparam int unsigned SUM_W = ACC_W + 1;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
    } ns_t;

    ns_t              st_d, st_q;
    logic [SUM_W-1:0] step_ext;
    logic [SUM_W-1:0] mod_ext;
    logic [SUM_W-1:0] sum;
    logic [SUM_W-1:0] diff;
    logic             wrap;

    always_comb begin
        step_ext = {{EXT_W{1'b0}}, step_i};
        mod_ext  = {1'b0, modulo_i, {PAD_W{1'b0}}};
        sum      = {1'b0, st_q.acc} + step_ext;
        diff     = sum - mod_ext;
        wrap     = (sum >= mod_ext);
        st_d     = st_q;
        if (clr_i) begin
            st_d.acc = '0;
        end else if (tload_i) begin
            st_d.acc = {tload_ns_i, {PAD_W{1'b0}}};
        end else if (wrap) begin
            st_d.acc = diff[ACC_W-1:0];
        end else begin
            st_d.acc = sum[ACC_W-1:0];
        end
        carry_o = wrap && !clr_i && !tload_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ns_o = st_q.acc[ACC_W-1:PAD_W];

    // R4: a time load shows exactly the loaded nanoseconds
    p_tload_exact_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tload_i && !clr_i) |=> ns_o == $past(tload_ns_i));

    // R2: a zero step with an in-range value leaves the time still
    p_zero_step_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i == '0 && {1'b0, st_q.acc} < mod_ext && !clr_i && !tload_i) |=> $stable(ns_o));

    // R3: a carry with a step below the rollover moves the value backwards
    p_carry_drops_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (carry_o && step_ext < mod_ext) |=> st_q.acc < $past(st_q.acc));

endmodule

// File: rtl/tod_sec_count.sv
module tod_sec_count #(
    parameter int unsigned SEC_W = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             tload_i,
    input  logic [SEC_W-1:0] tload_sec_i,
    input  logic             carry_i,
    output logic [SEC_W-1:0] sec_o
);
    localparam logic [SEC_W-1:0] SEC_ONE = 1;

    typedef struct packed {
        logic [SEC_W-1:0] sec;
    } sec_t;

    sec_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.sec = '0;
        end else if (tload_i) begin
            st_d.sec = tload_sec_i;
        end else if (carry_i) begin
            st_d.sec = st_q.sec + SEC_ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sec_o = st_q.sec;

    // R3: without a carry or a strobe the seconds hold
    p_sec_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !tload_i && !carry_i) |=> $stable(sec_o));

    // R10: a carry adds exactly one second, modulo the counter width
    p_sec_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !tload_i && carry_i) |=> sec_o == $past(sec_o) + SEC_ONE);

endmodule

// File: rtl/ptp_tod_clock.sv
module ptp_tod_clock #(
    parameter int unsigned SEC_W      = tod_pkg::SEC_W_DEF,
    parameter int unsigned NS_INT_W   = tod_pkg::NS_INT_W_DEF,
    parameter int unsigned NS_VIS_W   = tod_pkg::NS_VIS_FRAC_DEF,
    parameter int unsigned ACC_FRAC_W = tod_pkg::ACC_FRAC_W_DEF,
    parameter int unsigned STEP_INT_W = tod_pkg::STEP_INT_W_DEF,
    parameter int unsigned SLEW_CNT_W = tod_pkg::SLEW_CNT_W_DEF,
    localparam int unsigned NS_OUT_W  = NS_INT_W + NS_VIS_W,
    localparam int unsigned STEP_W    = STEP_INT_W + ACC_FRAC_W,
    localparam int unsigned ACC_W     = NS_INT_W + ACC_FRAC_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr_pulse_i,
    input  logic                  tload_pulse_i,
    input  logic [SEC_W-1:0]      tload_sec_i,
    input  logic [NS_OUT_W-1:0]   tload_ns_i,
    input  logic                  rate_load_pulse_i,
    input  logic [STEP_W-1:0]     rate_i,
    input  logic                  slew_load_pulse_i,
    input  logic [SLEW_CNT_W-1:0] slew_cycles_i,
    input  logic [STEP_W-1:0]     slew_rate_i,
    input  logic [NS_OUT_W-1:0]   ns_modulo_i,
    output logic [SEC_W-1:0]      sec_o,
    output logic [NS_OUT_W-1:0]   ns_o
);
    logic [STEP_W-1:0] step;
    logic              carry;

    tod_rate_ctrl #(
        .STEP_W (STEP_W),
        .CNT_W  (SLEW_CNT_W)
    ) u_rate (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (clr_pulse_i),
        .rate_ld_i   (rate_load_pulse_i),
        .rate_i      (rate_i),
        .slew_ld_i   (slew_load_pulse_i),
        .slew_cnt_i  (slew_cycles_i),
        .slew_rate_i (slew_rate_i),
        .step_o      (step)
    );

    tod_ns_accum #(
        .ACC_W    (ACC_W),
        .STEP_W   (STEP_W),
        .NS_OUT_W (NS_OUT_W)
    ) u_ns (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (clr_pulse_i),
        .tload_i    (tload_pulse_i),
        .tload_ns_i (tload_ns_i),
        .step_i     (step),
        .modulo_i   (ns_modulo_i),
        .ns_o       (ns_o),
        .carry_o    (carry)
    );

    tod_sec_count #(
        .SEC_W (SEC_W)
    ) u_sec (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (clr_pulse_i),
        .tload_i     (tload_pulse_i),
        .tload_sec_i (tload_sec_i),
        .carry_i     (carry),
        .sec_o       (sec_o)
    );

    // R9: a clear overrides every other strobe on the same cycle
    p_clr_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_pulse_i |=> (sec_o == '0 && ns_o == '0));

    // R1: reset state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_reset_zero_r1: assert (sec_o == '0 && ns_o == '0);
        end
    end

endmodule

// File: tb/ptp_tod_clock_tb.sv
module ptp_tod_clock_tb;

    localparam time CLK_PERIOD = 10;

    logic        clk;
    logic        rst_n;
    logic        clr_pulse_i;
    logic        tload_pulse_i;
    logic [47:0] tload_sec_i;
    logic [37:0] tload_ns_i;
    logic        rate_load_pulse_i;
    logic [39:0] rate_i;
    logic        slew_load_pulse_i;
    logic [31:0] slew_cycles_i;
    logic [39:0] slew_rate_i;
    logic [37:0] ns_modulo_i;
    logic [47:0] sec_o;
    logic [37:0] ns_o;

    int checks   = 0;
    int failures = 0;

    ptp_tod_clock u_dut (
        .clk               (clk),
        .rst_n             (rst_n),
        .clr_pulse_i       (clr_pulse_i),
        .tload_pulse_i     (tload_pulse_i),
        .tload_sec_i       (tload_sec_i),
        .tload_ns_i        (tload_ns_i),
        .rate_load_pulse_i (rate_load_pulse_i),
        .rate_i            (rate_i),
        .slew_load_pulse_i (slew_load_pulse_i),
        .slew_cycles_i     (slew_cycles_i),
        .slew_rate_i       (slew_rate_i),
        .ns_modulo_i       (ns_modulo_i),
        .sec_o             (sec_o),
        .ns_o              (ns_o)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    // 30.8 nanosecond value from integer and 1/256 parts
    function automatic logic [37:0] nsv(input int whole, input int frac8);
        return 38'(whole) * 38'd256 + 38'(frac8);
    endfunction

    // 8.32 step from integer and 32-bit fraction
    function automatic logic [39:0] stp(input int whole, input logic [31:0] frac);
        return {8'(whole), frac};
    endfunction

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic chk_time(input string req, input logic [47:0] s, input logic [37:0] n);
        check(req, "sec", {16'd0, sec_o}, {16'd0, s});
        check(req, "ns",  {26'd0, ns_o},  {26'd0, n});
    endtask

    // Drive the chosen strobes for one cycle; returns on the next falling edge
    task automatic strobe(input bit c, input bit t, input bit r, input bit s);
        clr_pulse_i       = c;
        tload_pulse_i     = t;
        rate_load_pulse_i = r;
        slew_load_pulse_i = s;
        @(negedge clk);
        clr_pulse_i       = 1'b0;
        tload_pulse_i     = 1'b0;
        rate_load_pulse_i = 1'b0;
        slew_load_pulse_i = 1'b0;
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_clear();
        strobe(1'b1, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic load_rate(input logic [39:0] v);
        rate_i = v;
        strobe(1'b0, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic load_time(input logic [47:0] s, input logic [37:0] n);
        tload_sec_i = s;
        tload_ns_i  = n;
        strobe(1'b0, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic load_slew(input logic [31:0] n, input logic [39:0] v);
        slew_cycles_i = n;
        slew_rate_i   = v;
        strobe(1'b0, 1'b0, 1'b0, 1'b1);
    endtask

    task automatic t_reset();
        chk_time("R1", 48'd0, nsv(0, 0));
        run(3);
        chk_time("R1", 48'd0, nsv(0, 0));
    endtask

    task automatic t_accumulate();
        do_clear();
        load_rate(stp(10, 32'h8000_0000));
        check("R5", "old step on load cycle", {26'd0, ns_o}, {26'd0, nsv(0, 0)});
        run(3);
        chk_time("R2", 48'd0, nsv(31, 128));
    endtask

    task automatic t_fraction();
        do_clear();
        load_rate(stp(0, 32'h0080_0000));
        run(1);
        check("R2", "half lsb hidden", {26'd0, ns_o}, {26'd0, nsv(0, 0)});
        run(1);
        check("R2", "two halves", {26'd0, ns_o}, {26'd0, nsv(0, 1)});
    endtask

    task automatic t_wrap();
        do_clear();
        load_time(48'd5, nsv(999, 0));
        load_rate(stp(3, 32'h0));
        chk_time("R4", 48'd5, nsv(999, 0));
        run(1);
        chk_time("R3", 48'd6, nsv(2, 0));
        do_clear();
        load_time(48'd5, nsv(995, 0));
        load_rate(stp(2, 32'h8000_0000));
        run(1);
        chk_time("R3", 48'd5, nsv(997, 128));
        run(1);
        chk_time("R11", 48'd6, nsv(0, 0));
        run(1);
        chk_time("R11", 48'd6, nsv(2, 128));
    endtask

    task automatic t_sec_wrap();
        do_clear();
        load_rate(stp(3, 32'h0));
        load_time(48'hFFFF_FFFF_FFFF, nsv(999, 0));
        chk_time("R4", 48'hFFFF_FFFF_FFFF, nsv(999, 0));
        run(1);
        chk_time("R10", 48'd0, nsv(2, 0));
    endtask

    task automatic t_priority();
        do_clear();
        load_rate(stp(3, 32'h0));
        run(2);
        check("R2", "two steps", {26'd0, ns_o}, {26'd0, nsv(6, 0)});
        tload_sec_i = 48'd7;
        tload_ns_i  = nsv(100, 0);
        strobe(1'b1, 1'b1, 1'b0, 1'b0);
        chk_time("R9", 48'd0, nsv(0, 0));
        load_rate(stp(3, 32'h0));
        load_time(48'd9, nsv(100, 0));
        chk_time("R4", 48'd9, nsv(100, 0));
        run(1);
        chk_time("R2", 48'd9, nsv(103, 0));
        rate_i = stp(7, 32'h0);
        strobe(1'b1, 1'b0, 1'b1, 1'b0);
        run(2);
        chk_time("R9", 48'd0, nsv(0, 0));
        slew_cycles_i = 32'd4;
        slew_rate_i   = stp(5, 32'h0);
        strobe(1'b1, 1'b0, 1'b0, 1'b1);
        run(2);
        chk_time("R9", 48'd0, nsv(0, 0));
    endtask

    task automatic t_slew();
        do_clear();
        load_rate(stp(1, 32'h0));
        load_slew(32'd3, stp(5, 32'h0));
        check("R6", "load cycle normal", {26'd0, ns_o}, {26'd0, nsv(1, 0)});
        run(1);
        check("R6", "first alt", {26'd0, ns_o}, {26'd0, nsv(6, 0)});
        run(2);
        check("R6", "three alt", {26'd0, ns_o}, {26'd0, nsv(16, 0)});
        run(2);
        check("R6", "normal again", {26'd0, ns_o}, {26'd0, nsv(18, 0)});
        load_slew(32'd5, stp(5, 32'h0));
        run(1);
        check("R6", "second slew", {26'd0, ns_o}, {26'd0, nsv(24, 0)});
        do_clear();
        chk_time("R8", 48'd0, nsv(0, 0));
        load_rate(stp(1, 32'h0));
        run(2);
        check("R8", "slew cancelled", {26'd0, ns_o}, {26'd0, nsv(2, 0)});
        load_slew(32'd0, stp(5, 32'h0));
        run(2);
        check("R7", "zero slew", {26'd0, ns_o}, {26'd0, nsv(5, 0)});
    endtask

    task automatic t_clear();
        do_clear();
        load_rate(stp(4, 32'h0));
        load_time(48'd33, nsv(10, 0));
        run(2);
        chk_time("R8", 48'd33, nsv(18, 0));
        do_clear();
        chk_time("R8", 48'd0, nsv(0, 0));
        run(3);
        chk_time("R8", 48'd0, nsv(0, 0));
    endtask

    initial begin
        rst_n             = 1'b0;
        clr_pulse_i       = 1'b0;
        tload_pulse_i     = 1'b0;
        rate_load_pulse_i = 1'b0;
        slew_load_pulse_i = 1'b0;
        tload_sec_i       = '0;
        tload_ns_i        = '0;
        rate_i            = '0;
        slew_cycles_i     = '0;
        slew_rate_i       = '0;
        ns_modulo_i       = nsv(1000, 0);
        run(3);
        chk_time("R1", 48'd0, nsv(0, 0));
        rst_n = 1'b1;
        run(1);
        t_reset();
        t_accumulate();
        t_fraction();
        t_wrap();
        t_sec_wrap();
        t_priority();
        t_slew();
        t_clear();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule